// File: doc/BRIEF.md
# Flag-Setting 8-Bit Arithmetic and Logic Unit

This block performs one of nine byte-wide operations on two source operands, B and C, selected by a 4-bit function code. When the enable input is high on a rising clock edge and the function code names a valid operation, the block latches the operation result into its result register A. In the same edge it updates a carry flag, a zero flag and a sign flag. A sequencer that steps through instructions drives the function code and the enable, and it reads the result and the flags back in the next cycle, for example to decide on conditional branches.

Each operation has its own rule for the flags. The logical operations always clear carry. A right shift always clears the sign flag, because a zero enters at the top. Clear loads a fixed set of flag values. Unused function codes, and cycles with the enable low, leave the result register and all three flags exactly as they were.

Top module: `alu8_flags`

## Requirements
- R1: While rst_n is low, and directly after it rises, acc is 0x00, cf is 0, zf is 1 and nf is 0.
- R2: The function codes are AND=0, OR=1, SHL=2, SHR=3, ADD=4, INC=5, DEC=6, NOT=7 and CLR=8. AND gives opb&opc, OR gives opb|opc and NOT gives ~opb. All three clear cf.
- R3: SHL gives opb shifted left by one with a 0 shifted into bit 0, and cf takes opb bit 7.
- R4: SHR gives opb shifted right by one with a 0 shifted into bit 7. cf takes opb bit 0, and nf is 0.
- R5: ADD gives (opb+opc) mod 256, and cf is the carry out of bit 7.
- R6: INC gives (opb+1) mod 256, and cf is the carry out of bit 7 (set only when opb is 0xFF).
- R7: DEC gives (opb-1) mod 256, and cf is 1 exactly when opb is 0x00 (borrow).
- R8: CLR sets acc to 0x00, cf to 0, zf to 1 and nf to 0, whatever the operands are.
- R9: After any update, zf is 1 exactly when the new acc is 0x00, and nf equals bit 7 of the new acc.
- R10: With en low, acc, cf, zf and nf keep their values on the clock edge, whatever the function code and operands are.
- R11: With en high and a function code from 9 to 15, acc, cf, zf and nf keep their values.
- R12: The result and the flags of an enabled operation appear on the outputs after the first rising clock edge at which it is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Operation enable |
| func | input | 4 | Function code (see R2) |
| opb | input | 8 | First source operand B |
| opc | input | 8 | Second source operand C |
| acc | output | 8 | Result register A |
| cf | output | 1 | Carry flag |
| zf | output | 1 | Zero flag, 1 when acc is zero |
| nf | output | 1 | Sign flag, bit 7 of acc |

## Verification
The bench goes after the carry edges:
- ADD overflowing to exactly zero, where a design that drops the ninth bit would miss both cf and zf.
- INC of 0xFF.
- DEC of 0x00, where a design that inverted the borrow sense would set cf on every other decrement.

Shifts are applied to operands with bit 0 or bit 7 set, which catches a design that takes carry from the wrong end or fills SHR with something other than zero. The logical operations are run after a carry has been set, so a design that leaves the old carry in place is caught. Disabled cycles and codes 9 to 15 are applied with operands that would change every output; a design that decodes too many codes or ignores the enable would then alter the outputs.

// File: rtl/alu8_flags.sv
module alu8_flags #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [3:0]       func,
  input  logic [WIDTH-1:0] opb,
  input  logic [WIDTH-1:0] opc,
  output logic [WIDTH-1:0] acc,
  output logic             cf,
  output logic             zf,
  output logic             nf
);
  localparam int MSB = WIDTH - 1;
  localparam logic [3:0] F_AND = 4'd0, F_OR = 4'd1, F_SHL = 4'd2, F_SHR = 4'd3,
                         F_ADD = 4'd4, F_INC = 4'd5, F_DEC = 4'd6, F_NOT = 4'd7,
                         F_CLR = 4'd8;

  logic [WIDTH:0]   sum, inc;
  logic [WIDTH-1:0] dec, r;
  logic             c_n, upd;

  assign sum = {1'b0, opb} + {1'b0, opc};
  assign inc = {1'b0, opb} + {{WIDTH{1'b0}}, 1'b1};
  assign dec = opb - {{(WIDTH-1){1'b0}}, 1'b1};

  always_comb begin
    upd = 1'b1;
    r   = '0;
    c_n = 1'b0;
    case (func)
      F_AND: r = opb & opc;
      F_OR:  r = opb | opc;
      F_SHL: begin r = {opb[MSB-1:0], 1'b0}; c_n = opb[MSB]; end
      F_SHR: begin r = {1'b0, opb[MSB:1]};   c_n = opb[0];   end
      F_ADD: begin r = sum[MSB:0]; c_n = sum[WIDTH]; end
      F_INC: begin r = inc[MSB:0]; c_n = inc[WIDTH]; end
      F_DEC: begin r = dec; c_n = (opb == '0); end
      F_NOT: r = ~opb;
      F_CLR: r = '0;
      default: upd = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
      cf  <= 1'b0;
      zf  <= 1'b1;
      nf  <= 1'b0;
    end else if (en && upd) begin
      acc <= r;
      cf  <= c_n;
      zf  <= (r == '0);
      nf  <= r[MSB];
    end
  end

  p_zero_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    zf == (acc == '0));
  p_sign_flag_r9: assert property (@(posedge clk) disable iff (!rst_n)
    nf == acc[MSB]);
  p_logic_clears_carry_r2: assert property (@(posedge clk) disable iff (!rst_n)
    en && (func == F_AND || func == F_OR || func == F_NOT) |=> !cf);
  p_shl_carry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    en && func == F_SHL |=> cf == $past(opb[MSB]));
  p_shr_sign_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    en && func == F_SHR |=> !nf && cf == $past(opb[0]));
  p_dec_borrow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    en && func == F_DEC |=> cf == ($past(opb) == '0));
  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    en && func == F_CLR |=> acc == '0 && !cf && zf && !nf);
  p_hold_disabled_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(acc) && $stable(cf) && $stable(zf) && $stable(nf));
  p_hold_unused_r11: assert property (@(posedge clk) disable iff (!rst_n)
    en && func > F_CLR |=> $stable(acc) && $stable(cf) && $stable(zf) && $stable(nf));
endmodule

// File: tb/alu8_flags_tb.sv
module alu8_flags_tb;
  logic       clk = 1'b0, rst_n = 1'b0, en = 1'b0;
  logic [3:0] func = 4'd0;
  logic [7:0] opb = 8'h00, opc = 8'h00;
  logic [7:0] acc;
  logic       cf, zf, nf;

  int n_vec = 0, n_bad = 0;
  bit done = 1'b0;

  logic [10:0] q_exp[$];
  string       q_tag[$];

  logic [7:0] m_acc = 8'h00;
  logic       m_cf = 1'b0, m_zf = 1'b1, m_nf = 1'b0;

  always #5 clk = ~clk;

  alu8_flags u_dut (.clk(clk), .rst_n(rst_n), .en(en), .func(func), .opb(opb),
                    .opc(opc), .acc(acc), .cf(cf), .zf(zf), .nf(nf));

  task automatic drive(input logic e, input logic [3:0] f, input logic [7:0] b,
                       input logic [7:0] c, input string tag);
    logic [8:0] w;
    logic [7:0] r;
    logic       k;
    logic       u;
    @(negedge clk);
    en = e; func = f; opb = b; opc = c;
    u = e;
    k = 1'b0;
    r = 8'h00;
    case (f)
      4'd0: r = b & c;
      4'd1: r = b | c;
      4'd2: begin r = {b[6:0], 1'b0}; k = b[7]; end
      4'd3: begin r = {1'b0, b[7:1]}; k = b[0]; end
      4'd4: begin w = b + c;     r = w[7:0]; k = w[8]; end
      4'd5: begin w = b + 9'd1;  r = w[7:0]; k = w[8]; end
      4'd6: begin r = b - 8'd1;  k = (b == 8'h00); end
      4'd7: r = ~b;
      4'd8: r = 8'h00;
      default: u = 1'b0;
    endcase
    if (u) begin
      m_acc = r; m_cf = k; m_zf = (r == 8'h00); m_nf = r[7];
    end
    q_exp.push_back({m_acc, m_cf, m_zf, m_nf});
    q_tag.push_back(tag);
  endtask

  // R12: each item is compared just after the first rising edge following its drive
  always @(posedge clk) begin
    #2;
    if (q_exp.size() > 0) begin
      logic [10:0] e;
      string t;
      e = q_exp.pop_front();
      t = q_tag.pop_front();
      n_vec++;
      if ({acc, cf, zf, nf} !== e) begin
        n_bad++;
        $display("FAIL %s: acc/cf/zf/nf = %h/%b/%b/%b, expected %h/%b/%b/%b",
                 t, acc, cf, zf, nf, e[10:3], e[2], e[1], e[0]);
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    n_vec++;
    if ({acc, cf, zf, nf} !== {8'h00, 3'b010}) begin
      n_bad++;
      $display("FAIL R1: acc/cf/zf/nf = %h/%b/%b/%b, expected 00/0/1/0", acc, cf, zf, nf);
    end
    rst_n = 1'b1;

    drive(1, 4'd0, 8'hF0, 8'h3C, "R2 AND");
    drive(1, 4'd0, 8'hF0, 8'h0F, "R2 AND zero R9");
    drive(1, 4'd2, 8'h81, 8'h00, "R3 SHL carry");
    drive(1, 4'd1, 8'h12, 8'h84, "R2 OR clears carry R9");
    drive(1, 4'd2, 8'h41, 8'h00, "R3 SHL no carry");
    drive(1, 4'd2, 8'h80, 8'h00, "R3 SHL to zero");
    drive(1, 4'd3, 8'h81, 8'h00, "R4 SHR carry");
    drive(1, 4'd3, 8'hFE, 8'h00, "R4 SHR zero fill");
    drive(1, 4'd3, 8'h01, 8'h00, "R4 SHR to zero");
    drive(1, 4'd4, 8'h12, 8'h34, "R5 ADD");
    drive(1, 4'd4, 8'hC0, 8'h50, "R5 ADD carry");
    drive(1, 4'd4, 8'h80, 8'h80, "R5 ADD carry zero");
    drive(1, 4'd7, 8'h0F, 8'h00, "R2 NOT clears carry");
    drive(1, 4'd4, 8'h70, 8'h10, "R5 ADD negative R9");
    drive(1, 4'd5, 8'h7F, 8'h00, "R6 INC");
    drive(1, 4'd5, 8'hFF, 8'h00, "R6 INC wrap");
    drive(1, 4'd6, 8'h01, 8'h00, "R7 DEC to zero");
    drive(1, 4'd6, 8'h00, 8'h00, "R7 DEC borrow");
    drive(0, 4'd8, 8'h55, 8'h55, "R10 disabled CLR");
    drive(0, 4'd4, 8'hFF, 8'h01, "R10 disabled ADD");
    drive(1, 4'd6, 8'h80, 8'h00, "R7 DEC no borrow");
    drive(1, 4'd8, 8'hFF, 8'hFF, "R8 CLR");
    drive(1, 4'd6, 8'h00, 8'h00, "R7 DEC borrow again");
    for (int f = 9; f < 16; f++)
      drive(1, f[3:0], 8'hFF, 8'h01, "R11 unused code");
    drive(1, 4'd8, 8'h00, 8'h00, "R8 CLR after borrow");
    drive(0, 4'd6, 8'h00, 8'h00, "R10 disabled DEC");
    drive(1, 4'd7, 8'h00, 8'h00, "R2 NOT to FF");
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end
endmodule